// File: doc/BRIEF.md
# UART Transmit Engine

This block turns a stream of bytes into asynchronous serial frames on one output line. Bytes come in over a valid/ready write port and wait in a small buffer. A serializer takes them one at a time and shifts each one out as a frame: a low start bit, eight data bits with the least significant bit first, an optional parity bit, and one or two high stop bits. A baud-tick input sets the bit timing. Each bit lasts a fixed number of tick pulses, and a new frame may only begin on a tick.

Line-control inputs are sampled when a frame begins, so the frame that is being sent is never altered. These inputs select parity on or off, even or odd parity, and one or two stop bits. A buffer-mode input chooses between the full buffer depth and a single holding slot. A break request drives the line low without interruption, but only after the frame in progress has ended. When the break is released, the line stays high for one bit time before any queued byte is sent. Status outputs report a full buffer, an empty buffer, and activity on the line.

Top module: `uart_tx_engine`

## Requirements
- R1: After reset, txd is 1, busy is 0, buf_empty is 1, buf_full is 0 and wr_ready is 1. Whenever busy is 0, txd is 1.
- R2: A frame is a 0 start bit, then 8 data bits with bit 0 first, then the stop bit(s) at 1. Every bit lasts TICKS_PER_BIT baud-tick pulses, and a frame starts only in a cycle where baud_tick is 1.
- R3: With cfg_par_en=1, a parity bit follows bit 7. With cfg_par_even=1, the data ones plus the parity bit total an even count. With cfg_par_even=0, they total an odd count.
- R4: With cfg_par_en=0, the stop bit follows bit 7 directly, and cfg_par_even has no effect.
- R5: With cfg_two_stop=1, the frame ends with two stop bit times at 1 before the next start bit can begin. With cfg_two_stop=0, it ends with one.
- R6: With cfg_fifo_en=1, the buffer accepts up to DEPTH bytes. When it is full, buf_full is 1, wr_ready is 0, and a refused write is never transmitted.
- R7: With cfg_fifo_en=0, the buffer holds at most one byte. buf_full is 1 whenever that byte is waiting.
- R8: When cfg_break becomes 1 during a frame, that frame completes normally. After it, txd stays 0 for as long as cfg_break stays 1, and queued bytes stay in the buffer.
- R9: After cfg_break falls, txd is 1 from the next cycle for one bit time. Queued bytes then resume, each beginning with a new start bit.
- R10: The parity and stop settings are captured when a frame starts. Changes during the frame apply only to later frames.
- R11: busy is 1 while a frame, a break, or the high time after a break is in progress. It returns to 0 once the buffer is drained and the line is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse from the fractional baud divisor |
| wr_data | input | 8 | Byte to queue |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Buffer can take a byte this cycle |
| cfg_fifo_en | input | 1 | 1: full buffer depth, 0: one holding slot |
| cfg_two_stop | input | 1 | 1: two stop bits |
| cfg_par_en | input | 1 | 1: append a parity bit |
| cfg_par_even | input | 1 | 1: even parity, 0: odd parity |
| cfg_break | input | 1 | Hold the line low after the current frame |
| txd | output | 1 | Serial output, idle high |
| buf_full | output | 1 | Buffer at its current capacity |
| buf_empty | output | 1 | No byte waiting |
| busy | output | 1 | Line activity in progress |

## Verification
The bench builds the engine with DEPTH=4 and TICKS_PER_BIT=4, and generates a tick every third clock, so one bit lasts exactly 12 clocks. The shallow buffer lets a few back-to-back writes reach the full limit and refused writes. The short bit makes the scoreboard's mid-bit sampling cheap enough to check frames with and without parity, with both parity senses and both stop lengths, settings changed during a frame, and a break that arrives during a frame. With frames of this length, a break can be held for many bit times and then released within the run.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4,
        ST_BREAK = 3'd5,
        ST_MARK  = 3'd6
    } tx_state_e;

    typedef struct packed {
        logic par_en;
        logic par_even;
        logic two_stop;
    } frame_cfg_t;

    function automatic logic parity_bit(input logic [BYTE_W-1:0] d, input logic even);
        return even ? (^d) : (~^d);
    endfunction

endpackage

// File: rtl/uart_tx_buf.sv
module uart_tx_buf
    import uart_tx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          one_slot,
    input  logic                          push_req,
    input  logic [BYTE_W-1:0]             push_data,
    input  logic                          pop,
    output logic [BYTE_W-1:0]             head,
    output logic                          full,
    output logic                          empty,
    output logic [$clog2(DEPTH+1)-1:0]    count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     limit;
    logic              push;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign limit = one_slot ? CW'(1) : CW'(DEPTH);
    assign full  = (count >= limit);
    assign empty = (count == '0);
    assign push  = push_req && !full;
    assign head  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= ptr_next(wr_ptr);
            if (pop)  rd_ptr <= ptr_next(rd_ptr);
            count <= count + CW'(push) - CW'(pop);
        end
    end
endmodule

// File: rtl/uart_tx_bitclk.sv
module uart_tx_bitclk #(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic baud_tick,
    input  logic run,
    output logic bit_end
);
    localparam int TW = $clog2(TICKS_PER_BIT);

    logic [TW-1:0] tcnt;
    logic          last;

    assign last    = (tcnt == TW'(TICKS_PER_BIT - 1));
    assign bit_end = run && baud_tick && last;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            tcnt <= '0;
        end else if (baud_tick) begin
            tcnt <= last ? '0 : tcnt + 1'b1;
        end
    end
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
    import uart_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              bit_end,
    input  logic              have_byte,
    input  logic [BYTE_W-1:0] byte_in,
    input  frame_cfg_t        live_cfg,
    input  logic              brk_req,
    output logic              pop,
    output logic              bit_run,
    output logic              txd,
    output tx_state_e         state
);
    localparam int IW = $clog2(BYTE_W);

    logic [BYTE_W-1:0] shreg;
    logic [IW-1:0]     idx;
    logic              second_stop;
    logic              par_q;
    frame_cfg_t        fcfg;
    logic              start_ok;

    assign start_ok = baud_tick && have_byte && !brk_req;
    assign pop      = (state == ST_IDLE) && start_ok;
    assign bit_run  = (state == ST_START) || (state == ST_DATA) || (state == ST_PAR) ||
                      (state == ST_STOP)  || (state == ST_MARK);

    always_comb begin
        unique case (state)
            ST_START: txd = 1'b0;
            ST_DATA:  txd = shreg[0];
            ST_PAR:   txd = par_q;
            ST_BREAK: txd = 1'b0;
            default:  txd = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            shreg       <= '0;
            idx         <= '0;
            second_stop <= 1'b0;
            par_q       <= 1'b0;
            fcfg        <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (brk_req) begin
                        state <= ST_BREAK;
                    end else if (start_ok) begin
                        state <= ST_START;
                        shreg <= byte_in;
                        fcfg  <= live_cfg;
                        par_q <= parity_bit(byte_in, live_cfg.par_even);
                    end
                end
                ST_START: begin
                    if (bit_end) begin
                        state <= ST_DATA;
                        idx   <= '0;
                    end
                end
                ST_DATA: begin
                    if (bit_end) begin
                        shreg <= shreg >> 1;
                        if (idx == IW'(BYTE_W - 1)) begin
                            state       <= fcfg.par_en ? ST_PAR : ST_STOP;
                            second_stop <= 1'b0;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                ST_PAR: begin
                    if (bit_end) begin
                        state       <= ST_STOP;
                        second_stop <= 1'b0;
                    end
                end
                ST_STOP: begin
                    if (bit_end) begin
                        if (fcfg.two_stop && !second_stop) second_stop <= 1'b1;
                        else                               state       <= ST_IDLE;
                    end
                end
                ST_BREAK: begin
                    if (!brk_req) state <= ST_MARK;
                end
                ST_MARK: begin
                    if (bit_end) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
    import uart_tx_pkg::*;
#(
    parameter int DEPTH         = 16,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       baud_tick,
    input  logic [7:0] wr_data,
    input  logic       wr_valid,
    output logic       wr_ready,
    input  logic       cfg_fifo_en,
    input  logic       cfg_two_stop,
    input  logic       cfg_par_en,
    input  logic       cfg_par_even,
    input  logic       cfg_break,
    output logic       txd,
    output logic       buf_full,
    output logic       buf_empty,
    output logic       busy
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [BYTE_W-1:0] head;
    logic [CNT_W-1:0]  fifo_cnt;
    logic              pop;
    logic              bit_run;
    logic              bit_end;
    tx_state_e         ser_st;
    frame_cfg_t        live_cfg;

    assign live_cfg = '{par_en: cfg_par_en, par_even: cfg_par_even, two_stop: cfg_two_stop};

    uart_tx_buf #(.DEPTH(DEPTH)) buf_i (
        .clk       (clk),
        .rst       (rst),
        .one_slot  (!cfg_fifo_en),
        .push_req  (wr_valid),
        .push_data (wr_data),
        .pop       (pop),
        .head      (head),
        .full      (buf_full),
        .empty     (buf_empty),
        .count     (fifo_cnt)
    );

    uart_tx_bitclk #(.TICKS_PER_BIT(TICKS_PER_BIT)) bitclk_i (
        .clk       (clk),
        .rst       (rst),
        .baud_tick (baud_tick),
        .run       (bit_run),
        .bit_end   (bit_end)
    );

    uart_tx_shifter shift_i (
        .clk       (clk),
        .rst       (rst),
        .baud_tick (baud_tick),
        .bit_end   (bit_end),
        .have_byte (!buf_empty),
        .byte_in   (head),
        .live_cfg  (live_cfg),
        .brk_req   (cfg_break),
        .pop       (pop),
        .bit_run   (bit_run),
        .txd       (txd),
        .state     (ser_st)
    );

    assign wr_ready = !buf_full;
    assign busy     = (ser_st != ST_IDLE);
endmodule

// File: rtl/uart_tx_engine_chk.sv
module uart_tx_engine_chk
    import uart_tx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       baud_tick,
    input logic                       wr_valid,
    input logic                       wr_ready,
    input logic                       cfg_fifo_en,
    input logic                       cfg_break,
    input logic                       txd,
    input logic                       buf_full,
    input logic                       buf_empty,
    input logic                       busy,
    input tx_state_e                  ser_st,
    input logic                       pop,
    input logic [$clog2(DEPTH+1)-1:0] fifo_cnt
);
    p_idle_line_high_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> txd);

    p_start_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
        (ser_st == ST_START && $past(ser_st) == ST_IDLE) |-> $past(baud_tick));

    p_fill_on_write_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready && buf_empty) |=> !buf_empty);

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        (buf_full && !pop) |=> (fifo_cnt <= $past(fifo_cnt)));

    p_single_slot_r7: assert property (@(posedge clk) disable iff (rst)
        (!cfg_fifo_en && !buf_empty) |-> buf_full);

    p_break_low_r8: assert property (@(posedge clk) disable iff (rst)
        (ser_st == ST_BREAK) |-> !txd);

    p_break_holds_r8: assert property (@(posedge clk) disable iff (rst)
        (ser_st == ST_BREAK && cfg_break) |=> (ser_st == ST_BREAK));

    p_break_no_pop_r8: assert property (@(posedge clk) disable iff (rst)
        (ser_st == ST_BREAK) |-> !pop);

    p_mark_after_break_r9: assert property (@(posedge clk) disable iff (rst)
        (ser_st == ST_BREAK && !cfg_break) |=> (ser_st == ST_MARK && txd));
endmodule

bind uart_tx_engine uart_tx_engine_chk #(.DEPTH(DEPTH)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .baud_tick   (baud_tick),
    .wr_valid    (wr_valid),
    .wr_ready    (wr_ready),
    .cfg_fifo_en (cfg_fifo_en),
    .cfg_break   (cfg_break),
    .txd         (txd),
    .buf_full    (buf_full),
    .buf_empty   (buf_empty),
    .busy        (busy),
    .ser_st      (ser_st),
    .pop         (pop),
    .fifo_cnt    (fifo_cnt)
);

// File: tb/uart_tx_engine_tb_top.sv
module uart_tx_engine_tb_top;
    localparam int DEPTH   = 4;
    localparam int TPB     = 4;
    localparam int TDIV    = 3;
    localparam int BIT_CLK = TPB * TDIV;

    typedef struct {
        logic [7:0] data;
        bit         par_en;
        bit         par_even;
        bit         two_stop;
    } exp_t;

    logic       clk = 0;
    logic       rst = 1;
    logic       baud_tick = 0;
    logic [7:0] wr_data = '0;
    logic       wr_valid = 0;
    logic       wr_ready;
    logic       cfg_fifo_en = 1;
    logic       cfg_two_stop = 0;
    logic       cfg_par_en = 0;
    logic       cfg_par_even = 0;
    logic       cfg_break = 0;
    logic       txd, buf_full, buf_empty, busy;

    int   n_checks = 0;
    int   n_fail = 0;
    int   frames_done = 0;
    int   frames_sent = 0;
    bit   mon_en = 1;
    bit   finished = 0;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    uart_tx_engine #(.DEPTH(DEPTH), .TICKS_PER_BIT(TPB)) dut_i (
        .clk(clk), .rst(rst), .baud_tick(baud_tick),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .cfg_fifo_en(cfg_fifo_en), .cfg_two_stop(cfg_two_stop),
        .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
        .cfg_break(cfg_break), .txd(txd), .buf_full(buf_full),
        .buf_empty(buf_empty), .busy(busy)
    );

    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            div = (div == TDIV - 1) ? 0 : div + 1;
            baud_tick = (div == 0);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic push_exp(input logic [7:0] d);
        exp_t e;
        e.data = d; e.par_en = cfg_par_en; e.par_even = cfg_par_even; e.two_stop = cfg_two_stop;
        exp_q.push_back(e);
        frames_sent++;
    endtask

    task automatic write_byte(input logic [7:0] d);
        @(negedge clk);
        wr_data = d; wr_valid = 1;
        while (!wr_ready) @(negedge clk);
        push_exp(d);
        @(posedge clk); #1 wr_valid = 0;
    endtask

    task automatic try_write(input logic [7:0] d, output bit acc);
        @(negedge clk);
        wr_data = d; wr_valid = 1;
        acc = wr_ready;
        if (acc) push_exp(d);
        @(posedge clk); #1 wr_valid = 0;
    endtask

    task automatic wait_busy_empty();
        do @(negedge clk); while (!(busy && buf_empty));
    endtask

    task automatic drain();
        while (frames_done < frames_sent) @(negedge clk);
        repeat (2 * BIT_CLK) @(negedge clk);
    endtask

    // scoreboard monitor: decodes each frame at mid-bit and compares with the queue
    initial begin
        bit prev = 1;
        forever begin
            @(negedge clk);
            if (mon_en && prev && !txd) begin
                logic [7:0] got;
                exp_t e;
                bit exp_par;
                repeat (BIT_CLK / 2 - 1) @(negedge clk);
                chk(txd == 0, "R2 start bit", txd, 0);
                for (int i = 0; i < 8; i++) begin
                    repeat (BIT_CLK) @(negedge clk);
                    got[i] = txd;
                end
                if (exp_q.size() == 0) begin
                    e.data = 'x; e.par_en = 0; e.par_even = 0; e.two_stop = 0;
                    chk(0, "R6 unexpected frame", got, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(got == e.data, "R2 data bits", got, e.data);
                end
                if (e.par_en) begin
                    exp_par = e.par_even ? ($countones(e.data) % 2 == 1) : ($countones(e.data) % 2 == 0);
                    repeat (BIT_CLK) @(negedge clk);
                    chk(txd == exp_par, "R3 parity bit", txd, exp_par);
                end
                repeat (BIT_CLK) @(negedge clk);
                chk(txd == 1, e.par_en ? "R2 stop bit" : "R4 stop follows data", txd, 1);
                if (e.two_stop) begin
                    repeat (BIT_CLK) @(negedge clk);
                    chk(txd == 1, "R5 second stop bit", txd, 1);
                end
                frames_done++;
            end
            prev = txd;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            chk(0, "watchdog expired", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        bit acc;
        int nacc;
        int highs;
        int target;
        repeat (5) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(txd == 1,       "R1 txd idle", txd, 1);
        chk(busy == 0,      "R1 busy",     busy, 0);
        chk(buf_empty == 1, "R1 empty",    buf_empty, 1);
        chk(buf_full == 0 && wr_ready == 1, "R1 full/ready", {buf_full, wr_ready}, 1);

        // R2 / R4: plain frames, parity disabled with both senses
        write_byte(8'hA5);
        write_byte(8'h3C);
        cfg_par_even = 1;
        write_byte(8'h0F);
        drain();

        // R3: even then odd parity
        cfg_par_en = 1; cfg_par_even = 1;
        write_byte(8'h01);
        write_byte(8'h03);
        drain();
        cfg_par_even = 0;
        write_byte(8'h01);
        write_byte(8'hFF);
        drain();

        // R5: two stop bits, back-to-back frames
        cfg_two_stop = 1;
        write_byte(8'h80);
        write_byte(8'h7E);
        drain();
        cfg_par_en = 0;
        write_byte(8'h55);
        write_byte(8'hAA);
        drain();
        cfg_two_stop = 0;

        // R6 / R11: full-depth buffer
        write_byte(8'h11);
        wait_busy_empty();
        chk(busy == 1, "R11 busy during frame", busy, 1);
        nacc = 0;
        for (int i = 0; i < DEPTH + 1; i++) begin
            try_write(8'h20 + 8'(i), acc);
            if (acc) nacc++;
        end
        chk(nacc == DEPTH, "R6 accepted count", nacc, DEPTH);
        @(negedge clk);
        chk(buf_full == 1 && wr_ready == 0, "R6 full blocks", {buf_full, wr_ready}, 2);
        drain();
        chk(busy == 0 && buf_empty == 1, "R11 idle after drain", {busy, buf_empty}, 1);

        // R7: single holding slot
        cfg_fifo_en = 0;
        write_byte(8'h42);
        wait_busy_empty();
        try_write(8'h43, acc);
        chk(acc == 1, "R7 one byte accepted", acc, 1);
        try_write(8'h44, acc);
        chk(acc == 0, "R7 second byte refused", acc, 0);
        @(negedge clk);
        chk(buf_full == 1, "R7 full with one byte", buf_full, 1);
        drain();
        cfg_fifo_en = 1;

        // R10: settings changed mid-frame apply only to later frames
        write_byte(8'h9D);
        wait_busy_empty();
        cfg_par_en = 1; cfg_par_even = 1; cfg_two_stop = 1;
        drain();
        write_byte(8'h9D);
        drain();
        chk(exp_q.size() == 0, "R10 queue drained", exp_q.size(), 0);
        cfg_par_en = 0; cfg_par_even = 0; cfg_two_stop = 0;

        // R8 / R9: break requested during a frame
        target = frames_done + 1;
        write_byte(8'hC3);
        wait_busy_empty();
        cfg_break = 1;
        write_byte(8'h96);
        while (frames_done < target) @(negedge clk);
        mon_en = 0;
        repeat (BIT_CLK) @(negedge clk);
        highs = 0;
        for (int i = 0; i < 10 * BIT_CLK; i++) begin
            @(negedge clk);
            if (txd) highs++;
        end
        chk(highs == 0, "R8 line held low", highs, 0);
        chk(busy == 1 && buf_empty == 0, "R8 queued byte held", {busy, buf_empty}, 2);
        mon_en = 1;
        @(negedge clk);
        cfg_break = 0;
        @(negedge clk);
        chk(txd == 1, "R9 line high after release", txd, 1);
        highs = 0;
        for (int i = 0; i < BIT_CLK - 4; i++) begin
            @(negedge clk);
            if (txd) highs++;
        end
        chk(highs == BIT_CLK - 4, "R9 high for a bit time", highs, BIT_CLK - 4);
        drain();
        chk(exp_q.size() == 0 && frames_done == frames_sent, "R9 queued byte resumed",
            frames_done, frames_sent);
        chk(busy == 0 && txd == 1, "R1 idle at end", {busy, txd}, 1);

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule